// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block turns a set of eight cumulative row-boundary values into a chip-select row map, and then uses that map to resolve a 22-bit page number (4 KiB pages) to the row that holds it. A row's boundary gives the total memory held by that row and all rows below it. A row with no memory repeats the boundary of the row before it. The boundary unit is 32 MiB or 64 MiB. Next to the map, the block reports each row's page span, the pages held per channel, the DRAM device width and the error-correction scheme in effect. These are derived from a row-attribute word and a controller-mode word.

The configuration inputs are plain register ports. The row map outputs follow them combinationally. A page lookup starts with a one-cycle valid strobe. The row index and the miss flag for that page appear one clock later, together with a one-cycle result pulse, and stay held until the next lookup. A variant-select input says whether the part can run in single-channel mode. Only such a part takes the unit size and the channel count from the mode word.

Top module: `dram_row_decoder`

## Requirements
- R1: With variantSel=1, mode bits 19:18 equal to 0 select a 32 MiB unit, so a row's page boundary is its 8-bit value shifted left by 13. With variantSel=1 and any nonzero value in those bits, or with variantSel=0, the unit is 64 MiB and the shift is 14.
- R2: dualChan equals mode bit 22 when variantSel=1, and is 1 when variantSel=0.
- R3: Row i is populated only if its page boundary is greater than the largest boundary of rows 0..i-1 (0 for row 0). An unpopulated row reports first page 0, last page 0 and a page count of 0.
- R4: A populated row reports as its first page the largest boundary of the rows below it, and as its last page its own boundary minus one.
- R5: The per-channel page count of a populated row is its span (last minus first plus one) halved when dualChan=1, and the full span when dualChan=0.
- R6: rowIsX4[i] equals bit 4*i+3 of the attribute word (1 = x4 devices, 0 = x8).
- R7: Each row's 2-bit field rowEcc[2i+1:2i] is 2'b00 (none) when mode bits 21:20 are both 0. Otherwise it is 2'b10 (quad-symbol correct) when dualChan=1 and the row is x4, and 2'b01 (single-bit correct, double detect) in every other case. 2'b11 never appears.
- R8: One cycle after a cycle with lookupValid=1, hitValid is 1 and hitRow gives the populated row whose first page is at or below the sampled page and whose last page is at or above it. hitValid is 0 in every cycle that does not follow a lookupValid.
- R9: A sampled page at or above the largest boundary sets missFlag with hitRow 0. Any other page clears missFlag.
- R10: After reset, hitValid, missFlag and hitRow are 0 until the first lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bndVals | input | 64 | Eight 8-bit cumulative boundaries, row i in bits 8i+7:8i |
| rowAttr | input | 32 | Row attribute word, width flag of row i at bit 4i+3 |
| ctlMode | input | 32 | Controller mode word (bits 22, 21:20, 19:18 used) |
| variantSel | input | 1 | 1 = single-channel-capable variant |
| pageNum | input | 22 | Page number to look up |
| lookupValid | input | 1 | Lookup strobe |
| hitValid | output | 1 | Lookup result pulse |
| hitRow | output | 3 | Row holding the page |
| missFlag | output | 1 | Page lies beyond all populated rows |
| dualChan | output | 1 | Effective dual-channel mode |
| rowFirst | output | 176 | First page of each row, 22 bits per row |
| rowLast | output | 176 | Last page of each row, 22 bits per row |
| chanPages | output | 176 | Pages per channel of each row, 22 bits per row |
| rowIsX4 | output | 8 | Device width flag per row |
| rowEcc | output | 16 | ECC mode code per row, 2 bits per row |

## Verification
The assertions check, on every cycle, the result pulse timing and the hit placement. A reported hit must lie within the first and last page that its row showed when the page was sampled, and a miss must lie at or above every such last page. The ECC codes are also checked every cycle: 2'b11 never appears, and the quad-symbol code appears only on x4 rows in dual-channel mode. The exact unit scaling, the skipping of empty rows, the span halving and the width-bit positions can only be shown by the bench's scenarios. These compare every row's fields and every lookup against a reference model, on random monotone maps and on directed cases: an all-empty map, pages exactly on a boundary, the top of the page range, and the variant that ignores the mode bits.

// File: rtl/row_dec_pkg.sv
package row_dec_pkg;

  typedef enum logic [1:0] {
    ECC_NONE   = 2'b00,
    ECC_SECDED = 2'b01,
    ECC_QUAD   = 2'b10
  } eccCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
  } ctlStrb_t;

  // effective memory configuration decoded from the mode word
  typedef struct packed {
    logic wideUnit;  // 1: 64 MiB unit, 0: 32 MiB unit
    logic dualOn;
    logic eccOn;
  } modeCfg_t;

endpackage

// File: rtl/row_ctrl.sv
module row_ctrl
  import row_dec_pkg::*;
#(
  parameter int MODE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookupValid,
  input  logic [MODE_W-1:0] ctlMode,
  input  logic              variantSel,
  output ctlStrb_t          strb,
  output modeCfg_t          cfg,
  output logic              resValid
);
  localparam int DUAL_BIT = 22;
  localparam int GRAN_LO  = 18;
  localparam int ECC_LO   = 20;

  logic granNonZero;

  always_comb begin
    granNonZero  = |ctlMode[GRAN_LO +: 2];
    cfg.wideUnit = variantSel ? granNonZero : 1'b1;
    cfg.dualOn   = variantSel ? ctlMode[DUAL_BIT] : 1'b1;
    cfg.eccOn    = |ctlMode[ECC_LO +: 2];
    strb.capture = lookupValid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resValid <= 1'b0;
    else        resValid <= lookupValid;
  end

endmodule

// File: rtl/row_attr_decode.sv
module row_attr_decode
  import row_dec_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int ATTR_STRIDE = 4,
  parameter int ATTR_W = NUM_ROWS * ATTR_STRIDE
) (
  input  logic [ATTR_W-1:0]     rowAttr,
  input  modeCfg_t              cfg,
  output logic [NUM_ROWS-1:0]   rowIsX4,
  output logic [2*NUM_ROWS-1:0] rowEcc
);
  localparam int WIDTH_POS = ATTR_STRIDE - 1;

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    eccCode_t code;
    always_comb begin
      if (!cfg.eccOn)                          code = ECC_NONE;
      else if (cfg.dualOn && rowIsX4[i])       code = ECC_QUAD;
      else                                     code = ECC_SECDED;
    end
    assign rowIsX4[i]        = rowAttr[i*ATTR_STRIDE + WIDTH_POS];
    assign rowEcc[2*i +: 2]  = code;
  end

endmodule

// File: rtl/row_map_dp.sv
module row_map_dp
  import row_dec_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int BND_W    = 8,
  parameter int PAGE_W   = 22,
  parameter int BASE_SHIFT = 13,
  parameter int ROW_W    = $clog2(NUM_ROWS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_ROWS*BND_W-1:0]  bndVals,
  input  logic [PAGE_W-1:0]          pageNum,
  input  ctlStrb_t                   strb,
  input  modeCfg_t                   cfg,
  output logic [ROW_W-1:0]           hitRow,
  output logic                       missFlag,
  output logic [NUM_ROWS*PAGE_W-1:0] rowFirst,
  output logic [NUM_ROWS*PAGE_W-1:0] rowLast,
  output logic [NUM_ROWS*PAGE_W-1:0] chanPages
);
  logic [PAGE_W-1:0]   bndPage [NUM_ROWS];
  logic [PAGE_W-1:0]   prevMax [NUM_ROWS+1];
  logic [NUM_ROWS-1:0] populated;
  logic [NUM_ROWS-1:0] below;

  assign prevMax[0] = '0;

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    logic [PAGE_W-1:0] wideVal;
    logic [PAGE_W-1:0] span;
    assign wideVal    = PAGE_W'(bndVals[i*BND_W +: BND_W]);
    assign bndPage[i] = cfg.wideUnit ? (wideVal << (BASE_SHIFT + 1))
                                     : (wideVal << BASE_SHIFT);
    assign populated[i] = bndPage[i] > prevMax[i];
    assign prevMax[i+1] = populated[i] ? bndPage[i] : prevMax[i];
    assign span = bndPage[i] - prevMax[i];
    assign below[i] = pageNum < bndPage[i];

    assign rowFirst[i*PAGE_W +: PAGE_W]  = populated[i] ? prevMax[i] : '0;
    assign rowLast[i*PAGE_W +: PAGE_W]   = populated[i] ? bndPage[i] - 1'b1 : '0;
    assign chanPages[i*PAGE_W +: PAGE_W] = !populated[i] ? '0 :
                                           (cfg.dualOn ? (span >> 1) : span);
  end

  // lowest row whose boundary lies above the page
  logic [ROW_W-1:0] hitNext;
  logic             found;
  always_comb begin
    hitNext = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_ROWS; i++) begin
      if (!found && below[i]) begin
        hitNext = ROW_W'(i);
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hitRow   <= '0;
      missFlag <= 1'b0;
    end else if (strb.capture) begin
      hitRow   <= hitNext;
      missFlag <= !found;
    end
  end

endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder
  import row_dec_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int BND_W    = 8,
  parameter int PAGE_W   = 22,
  parameter int MODE_W   = 32,
  parameter int ATTR_STRIDE = 4,
  parameter int ROW_W    = $clog2(NUM_ROWS),
  parameter int ATTR_W   = NUM_ROWS * ATTR_STRIDE
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_ROWS*BND_W-1:0]  bndVals,
  input  logic [ATTR_W-1:0]          rowAttr,
  input  logic [MODE_W-1:0]          ctlMode,
  input  logic                       variantSel,
  input  logic [PAGE_W-1:0]          pageNum,
  input  logic                       lookupValid,
  output logic                       hitValid,
  output logic [ROW_W-1:0]           hitRow,
  output logic                       missFlag,
  output logic                       dualChan,
  output logic [NUM_ROWS*PAGE_W-1:0] rowFirst,
  output logic [NUM_ROWS*PAGE_W-1:0] rowLast,
  output logic [NUM_ROWS*PAGE_W-1:0] chanPages,
  output logic [NUM_ROWS-1:0]        rowIsX4,
  output logic [2*NUM_ROWS-1:0]      rowEcc
);
  ctlStrb_t strb;
  modeCfg_t cfg;

  row_ctrl #(.MODE_W(MODE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .lookupValid(lookupValid),
    .ctlMode(ctlMode), .variantSel(variantSel),
    .strb(strb), .cfg(cfg), .resValid(hitValid)
  );

  row_map_dp #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .bndVals(bndVals), .pageNum(pageNum),
    .strb(strb), .cfg(cfg), .hitRow(hitRow), .missFlag(missFlag),
    .rowFirst(rowFirst), .rowLast(rowLast), .chanPages(chanPages)
  );

  row_attr_decode #(.NUM_ROWS(NUM_ROWS), .ATTR_STRIDE(ATTR_STRIDE)) u_attr (
    .rowAttr(rowAttr), .cfg(cfg), .rowIsX4(rowIsX4), .rowEcc(rowEcc)
  );

  assign dualChan = cfg.dualOn;

endmodule

// File: rtl/dram_row_decoder_chk.sv
module dram_row_decoder_chk #(
  parameter int NUM_ROWS = 8,
  parameter int PAGE_W   = 22,
  parameter int ROW_W    = $clog2(NUM_ROWS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [PAGE_W-1:0]          pageNum,
  input logic                       lookupValid,
  input logic                       hitValid,
  input logic [ROW_W-1:0]           hitRow,
  input logic                       missFlag,
  input logic                       dualChan,
  input logic [NUM_ROWS*PAGE_W-1:0] rowFirst,
  input logic [NUM_ROWS*PAGE_W-1:0] rowLast,
  input logic [NUM_ROWS-1:0]        rowIsX4,
  input logic [2*NUM_ROWS-1:0]      rowEcc
);
  logic [PAGE_W-1:0]          smpPage;
  logic [NUM_ROWS*PAGE_W-1:0] smpFirst;
  logic [NUM_ROWS*PAGE_W-1:0] smpLast;
  logic                       smpHad;
  logic                       missOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smpPage <= '0; smpFirst <= '0; smpLast <= '0; smpHad <= 1'b0;
    end else if (lookupValid) begin
      smpPage <= pageNum; smpFirst <= rowFirst; smpLast <= rowLast; smpHad <= 1'b1;
    end
  end

  always_comb begin
    missOk = 1'b1;
    for (int i = 0; i < NUM_ROWS; i++)
      if (smpLast[i*PAGE_W +: PAGE_W] != '0 && smpPage <= smpLast[i*PAGE_W +: PAGE_W])
        missOk = 1'b0;
  end

  a_r8_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lookupValid |=> hitValid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lookupValid |=> !hitValid);
  a_r8_hit_in_span: assert property (@(posedge clk) disable iff (!rst_n)
    (hitValid && smpHad && !missFlag) |->
      (smpPage >= smpFirst[hitRow*PAGE_W +: PAGE_W] &&
       smpPage <= smpLast[hitRow*PAGE_W +: PAGE_W]));
  a_r9_miss_beyond: assert property (@(posedge clk) disable iff (!rst_n)
    (hitValid && missFlag) |-> (missOk && hitRow == '0));

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_ecc
    a_r7_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      rowEcc[2*i +: 2] != 2'b11);
    a_r7_quad_needs_x4: assert property (@(posedge clk) disable iff (!rst_n)
      (rowEcc[2*i +: 2] == 2'b10) |-> (dualChan && rowIsX4[i]));
  end

endmodule

bind dram_row_decoder dram_row_decoder_chk #(
  .NUM_ROWS(NUM_ROWS), .PAGE_W(PAGE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pageNum(pageNum), .lookupValid(lookupValid),
  .hitValid(hitValid), .hitRow(hitRow), .missFlag(missFlag),
  .dualChan(dualChan), .rowFirst(rowFirst), .rowLast(rowLast),
  .rowIsX4(rowIsX4), .rowEcc(rowEcc)
);

// File: tb/sim_dram_row_decoder.sv
module sim_dram_row_decoder;
  localparam int NR = 8;
  localparam int PW = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR*8-1:0] bndVals = '0;
  logic [31:0]   rowAttr = '0;
  logic [31:0]   ctlMode = '0;
  logic          variantSel = 1'b0;
  logic [PW-1:0] pageNum = '0;
  logic          lookupValid = 1'b0;
  logic          hitValid, missFlag, dualChan;
  logic [2:0]    hitRow;
  logic [NR*PW-1:0] rowFirst, rowLast, chanPages;
  logic [NR-1:0] rowIsX4;
  logic [2*NR-1:0] rowEcc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int eBnd [NR];
  int eFirst [NR];
  int eLast [NR];
  int ePages [NR];
  int eEcc [NR];
  int eDual;
  int eTotal;

  dram_row_decoder u0 (
    .clk(clk), .rst_n(rst_n), .bndVals(bndVals), .rowAttr(rowAttr),
    .ctlMode(ctlMode), .variantSel(variantSel), .pageNum(pageNum),
    .lookupValid(lookupValid), .hitValid(hitValid), .hitRow(hitRow),
    .missFlag(missFlag), .dualChan(dualChan), .rowFirst(rowFirst),
    .rowLast(rowLast), .chanPages(chanPages), .rowIsX4(rowIsX4), .rowEcc(rowEcc)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model();
    int sh, prev, span;
    bit wide;
    wide = variantSel ? (ctlMode[19:18] != 0) : 1'b1;  // R1
    sh = wide ? 14 : 13;
    eDual = variantSel ? int'(ctlMode[22]) : 1;          // R2
    prev = 0;
    for (int i = 0; i < NR; i++) begin
      eBnd[i] = int'(bndVals[i*8 +: 8]) << sh;
      if (eBnd[i] > prev) begin
        eFirst[i] = prev; eLast[i] = eBnd[i] - 1;
        span = eBnd[i] - prev;
        ePages[i] = eDual ? span / 2 : span;
        prev = eBnd[i];
      end else begin
        eFirst[i] = 0; eLast[i] = 0; ePages[i] = 0;
      end
      if (ctlMode[21:20] == 0) eEcc[i] = 0;
      else if (eDual == 1 && rowAttr[4*i+3]) eEcc[i] = 2;
      else eEcc[i] = 1;
    end
    eTotal = prev;
  endtask

  task automatic check_map();
    model();
    check(dualChan == eDual[0], "R2 dualChan", dualChan, eDual);
    for (int i = 0; i < NR; i++) begin
      check(rowFirst[i*PW +: PW] == eFirst[i], "R3/R4 first (R1 scale)", rowFirst[i*PW +: PW], eFirst[i]);
      check(rowLast[i*PW +: PW] == eLast[i], "R3/R4 last (R1 scale)", rowLast[i*PW +: PW], eLast[i]);
      check(chanPages[i*PW +: PW] == ePages[i], "R5 chanPages", chanPages[i*PW +: PW], ePages[i]);
      check(rowIsX4[i] == rowAttr[4*i+3], "R6 width", rowIsX4[i], rowAttr[4*i+3]);
      check(rowEcc[2*i +: 2] == eEcc[i], "R7 ecc", rowEcc[2*i +: 2], eEcc[i]);
    end
  endtask

  task automatic lookup(input int pg);
    int expRow, expMiss;
    @(negedge clk);
    pageNum = PW'(pg);
    lookupValid = 1'b1;
    model();
    expMiss = (pg >= eTotal) ? 1 : 0;
    expRow = 0;
    for (int i = NR - 1; i >= 0; i--) if (pg < eBnd[i]) expRow = i;
    if (expMiss == 1) expRow = 0;
    @(negedge clk);
    lookupValid = 1'b0;
    check(hitValid == 1'b1, "R8 hitValid pulse", hitValid, 1);
    check(missFlag == expMiss[0], "R9 missFlag", missFlag, expMiss);
    check(hitRow == expRow[2:0], "R8 hitRow", hitRow, expRow);
    check_map();
    @(negedge clk);
    check(hitValid == 1'b0, "R8 pulse ends", hitValid, 0);
    check(hitRow == expRow[2:0], "R8 hitRow held", hitRow, expRow);
  endtask

  task automatic rand_map();
    int acc;
    acc = 0;
    for (int i = 0; i < NR; i++) begin
      if ($urandom % 4 != 0) acc = acc + int'($urandom % 40);
      if (acc > 255) acc = 255;
      bndVals[i*8 +: 8] = 8'(acc);
    end
    rowAttr = $urandom;
    ctlMode = $urandom;
    variantSel = 1'($urandom);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(hitValid == 1'b0, "R10 hitValid", hitValid, 0);
    check(missFlag == 1'b0, "R10 missFlag", missFlag, 0);
    check(hitRow == 3'd0, "R10 hitRow", hitRow, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(hitValid == 1'b0, "R10 idle after reset", hitValid, 0);

    // all rows empty: everything misses (R3, R9)
    bndVals = '0; ctlMode = 32'h0030_0000; variantSel = 1'b0; rowAttr = 32'hFFFF_FFFF;
    lookup(0);

    // directed map, 32 MiB units, single channel (R1, R2, R5)
    bndVals = {8'd20, 8'd20, 8'd16, 8'd12, 8'd12, 8'd8, 8'd4, 8'd0};
    variantSel = 1'b1; ctlMode = 32'h0010_0000; rowAttr = 32'h8888_0008;
    lookup(4 << 13);          // exactly on boundary of row1 -> row 2
    lookup((4 << 13) - 1);    // last page of row1
    lookup((20 << 13) - 1);   // last populated page
    lookup(20 << 13);         // R9 first page beyond
    // same map, variant 0 ignores mode bits (R1, R2)
    variantSel = 1'b0; ctlMode = 32'h0000_0000;
    lookup(4 << 13);
    // dual channel via mode bit on capable variant (R2, R7)
    variantSel = 1'b1; ctlMode = 32'h0065_0000;
    lookup(100);
    // full top boundary with 64 MiB units (R9 at top of range)
    bndVals = {8'd255, 8'd200, 8'd150, 8'd100, 8'd60, 8'd30, 8'd10, 8'd1};
    variantSel = 1'b0;
    lookup((255 << 14) - 1);
    lookup(22'h3FFFFF);

    // random scenarios
    for (int n = 0; n < 300; n++) begin
      int pg;
      rand_map();
      model();
      case ($urandom % 3)
        0: pg = (eTotal > 0) ? int'($urandom % eTotal) : 0;
        1: pg = eBnd[$urandom % NR];
        default: pg = int'($urandom % (1 << PW));
      endcase
      lookup(pg);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule